// File: doc/BRIEF.md
# Configurable-Aspect Dual-Port Block RAM

This block is a behavioural, synthesizable model of a 5120-bit memory with one write port and one read port. Each port has its own clock, enable, address and data bus. A parameter sets the data bus width of each port, and the two ports may use different widths. The number of address bits each port uses follows from its width. Both ports always take a 12-bit address. A narrow-depth configuration decodes only the upper part of that address.

The array is built from 5-bit lanes. The full 5-bit lane layout applies only when both ports are 5, 10 or 20 bits wide. Any other pairing switches both ports to a narrower layout that keeps four bits per lane. In that layout, a 5, 10 or 20-bit bus carries payload only on the low four bits of each 5-bit group.

The read port is synchronous and has no extra output register. A parameter decides what a read sees when it hits the word being written on the same edge: the old data or the new data. Another parameter supplies the power-up contents. Each port can be set to sample on the rising or the falling clock edge.

Top module: `aspect_ram`

## Requirements
- R1: A port of effective width 1, 2, 4, 8 or 16 decodes the upper 12, 11, 10, 9 or 8 bits of its 12-bit address, respectively. Widths 5, 10 and 20 decode the same number of bits as 4, 8 and 16. The remaining low address bits have no effect.
- R2: The 5-bit lane layout is used only when both WR_W and RD_W are in {5, 10, 20}. Otherwise a 5, 10 or 20-bit bus carries 4, 8 or 16 payload bits, on bus bits [5g+3:5g] for each group g. In that case bit 5g+4 is ignored on write and reads as 0.
- R3: Storage is one flat bit space shared by both ports. A word of effective width E at decoded address a occupies flat bits a*E to a*E+E-1, with payload bit 0 at the lowest index. Mixed port widths therefore see each other's data bit for bit.
- R4: An active read-clock edge with rd_en high loads the addressed word into rd_data, which is visible after that edge. While rd_en is low at an active edge, rd_data keeps its value.
- R5: An active write-clock edge with wr_en low changes no storage bit.
- R6: An active write-clock edge with wr_en high stores the payload at the addressed word and leaves every other storage bit unchanged.
- R7: With COLLIDE = RD_OLD_DATA (encoding 0), a read on the same edge as a write returns the contents from before that write.
- R8: With COLLIDE = RD_NEW_DATA (encoding 1), every read bit that the same-edge write covers returns the new write data. Bits the write does not cover return stored data.
- R9: At power-up, flat bit k holds INIT bit k in the 5-bit lane layout. In the 4-bit layout it holds INIT bit 5*(k/4) + (k%4), so the fifth bit of each INIT lane is ignored.
- R10: WR_POL and RD_POL select the active edge of their port's clock: 1 for rising, 0 for falling.
- R11: Before the first enabled read, rd_data is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write port clock; active edge set by WR_POL |
| wr_en | input | 1 | Write enable, sampled on the active write edge |
| wr_addr | input | 12 | Write address; only the upper bits the width needs are decoded |
| wr_data | input | WR_W | Write data bus |
| rd_clk | input | 1 | Read port clock; active edge set by RD_POL |
| rd_en | input | 1 | Read enable, sampled on the active read edge |
| rd_addr | input | 12 | Read address; only the upper bits the width needs are decoded |
| rd_data | output | RD_W | Registered read data |

## Verification
Some properties are checked on every edge:
- rd_data holds while the read is disabled.
- The storage is untouched when wr_en is low.
- After an enabled write, the target word holds the payload.
- After an enabled write, no storage bit outside the target word has moved.

Other behaviours depend on how the two ports are configured, so only the bench scenarios can show them:
- how address bits are decoded;
- lane layout selection and padding;
- the mixed-width bit ordering;
- both collision outcomes;
- the initial image and edge polarity.

// File: rtl/aspect_ram_pkg.sv
package aspect_ram_pkg;

    localparam int ADDR_W      = 12;
    localparam int ARRAY_BITS  = 5120;
    localparam int FAW         = $clog2(ARRAY_BITS);
    localparam int LANE_WIDE   = 5;
    localparam int LANE_NARROW = 4;
    localparam int NARROW_BITS = (ARRAY_BITS / LANE_WIDE) * LANE_NARROW;

    typedef enum logic {
        RD_OLD_DATA = 1'b0,
        RD_NEW_DATA = 1'b1
    } collide_e;

    function automatic bit width_ok(input int w);
        return (w == 1) || (w == 2) || (w == 4) || (w == 5) ||
               (w == 8) || (w == 10) || (w == 16) || (w == 20);
    endfunction

    function automatic bit wide_lane_width(input int w);
        return (w == 5) || (w == 10) || (w == 20);
    endfunction

    // payload width of a bus once the lane layout is known
    function automatic int eff_width(input int w, input bit wide_lanes);
        if (wide_lanes || !wide_lane_width(w)) return w;
        return (w / LANE_WIDE) * LANE_NARROW;
    endfunction

    // number of decoded upper address bits for a payload width
    function automatic int addr_bits(input int eff);
        if (eff == 1) return 12;
        if (eff == 2) return 11;
        if (eff == 4 || eff == 5) return 10;
        if (eff == 8 || eff == 10) return 9;
        return 8;
    endfunction

endpackage

// File: rtl/aspect_ram_pack.sv
module aspect_ram_pack
    import aspect_ram_pkg::*;
#(
    parameter int BUS_W = 20,
    parameter int EFF_W = 20,
    parameter int ABITS = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  bus_data,
    output logic [FAW-1:0]    base,
    output logic [EFF_W-1:0]  word
);
    localparam int GROUPS = EFF_W / LANE_NARROW;

    logic [ABITS-1:0] field;
    logic             unused_bits;

    assign field       = addr[ADDR_W-1 -: ABITS];
    assign base        = FAW'(field) * FAW'(EFF_W);
    assign unused_bits = ^addr ^ ^bus_data;

    generate
        if (EFF_W == BUS_W) begin : g_direct
            assign word = bus_data;
        end else begin : g_skip
            for (genvar g = 0; g < GROUPS; g++) begin : g_grp
                assign word[g*LANE_NARROW +: LANE_NARROW] =
                    bus_data[g*LANE_WIDE +: LANE_NARROW];
            end
        end
    endgenerate

endmodule

// File: rtl/aspect_ram_unpack.sv
module aspect_ram_unpack
    import aspect_ram_pkg::*;
#(
    parameter int BUS_W = 20,
    parameter int EFF_W = 20
) (
    input  logic [EFF_W-1:0] word,
    output logic [BUS_W-1:0] bus_data
);
    localparam int GROUPS = EFF_W / LANE_NARROW;

    generate
        if (EFF_W == BUS_W) begin : g_direct
            assign bus_data = word;
        end else begin : g_skip
            for (genvar g = 0; g < GROUPS; g++) begin : g_grp
                assign bus_data[g*LANE_WIDE +: LANE_NARROW] =
                    word[g*LANE_NARROW +: LANE_NARROW];
                assign bus_data[g*LANE_WIDE + LANE_NARROW] = 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/aspect_ram_store.sv
module aspect_ram_store
    import aspect_ram_pkg::*;
#(
    parameter int                    WW         = 20,
    parameter int                    RW         = 20,
    parameter bit                    WIDE_LANES = 1'b1,
    parameter collide_e              COLLIDE    = RD_OLD_DATA,
    parameter logic [ARRAY_BITS-1:0] INIT       = '0
) (
    input  logic           wclk,
    input  logic           wr_en,
    input  logic [FAW-1:0] wr_base,
    input  logic [WW-1:0]  wr_word,
    input  logic           rclk,
    input  logic           rd_en,
    input  logic [FAW-1:0] rd_base,
    output logic [RW-1:0]  rd_word
);
    // flat image from the lane-spaced initial image
    function automatic logic [ARRAY_BITS-1:0] init_flat();
        logic [ARRAY_BITS-1:0] img;
        img = '0;
        for (int k = 0; k < ARRAY_BITS; k++) begin
            if (WIDE_LANES) begin
                img[k] = INIT[k];
            end else if (k < NARROW_BITS) begin
                img[k] = INIT[(k / LANE_NARROW) * LANE_WIDE + (k % LANE_NARROW)];
            end
        end
        return img;
    endfunction

    logic [ARRAY_BITS-1:0] mem_q = init_flat();
    logic [RW-1:0]         rd_q  = '0;
    logic [RW-1:0]         stored_word;
    logic [RW-1:0]         rd_next;

    always_ff @(posedge wclk) begin
        if (wr_en) begin
            for (int j = 0; j < WW; j++) begin
                mem_q[wr_base + FAW'(j)] <= wr_word[j];
            end
        end
    end

    always_comb begin
        for (int i = 0; i < RW; i++) begin
            stored_word[i] = mem_q[rd_base + FAW'(i)];
        end
    end

    generate
        if (COLLIDE == RD_NEW_DATA) begin : g_new
            always_comb begin
                rd_next = stored_word;
                if (wr_en) begin
                    for (int i = 0; i < RW; i++) begin
                        for (int j = 0; j < WW; j++) begin
                            if (wr_base + FAW'(j) == rd_base + FAW'(i)) begin
                                rd_next[i] = wr_word[j];
                            end
                        end
                    end
                end
            end
        end else begin : g_old
            assign rd_next = stored_word;
        end
    endgenerate

    always_ff @(posedge rclk) begin
        if (rd_en) begin
            rd_q <= rd_next;
        end
    end

    assign rd_word = rd_q;

endmodule

// File: rtl/aspect_ram.sv
module aspect_ram
    import aspect_ram_pkg::*;
#(
    parameter int                    WR_W    = 20,
    parameter int                    RD_W    = 20,
    parameter bit                    WR_POL  = 1'b1,
    parameter bit                    RD_POL  = 1'b1,
    parameter collide_e              COLLIDE = RD_OLD_DATA,
    parameter logic [ARRAY_BITS-1:0] INIT    = '0
) (
    input  logic              wr_clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WR_W-1:0]   wr_data,
    input  logic              rd_clk,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [RD_W-1:0]   rd_data
);
    localparam bit WIDE_LANES = wide_lane_width(WR_W) && wide_lane_width(RD_W);
    localparam int WR_EFF     = eff_width(WR_W, WIDE_LANES);
    localparam int RD_EFF     = eff_width(RD_W, WIDE_LANES);
    localparam int WR_AB      = addr_bits(WR_EFF);
    localparam int RD_AB      = addr_bits(RD_EFF);

    generate
        if (!width_ok(WR_W)) begin : g_bad_wr
            $error("aspect_ram: unsupported WR_W");
        end
        if (!width_ok(RD_W)) begin : g_bad_rd
            $error("aspect_ram: unsupported RD_W");
        end
    endgenerate

    logic              wclk_i;
    logic              rclk_i;
    logic [FAW-1:0]    wr_base;
    logic [FAW-1:0]    rd_base;
    logic [WR_EFF-1:0] wr_word;
    logic [RD_EFF-1:0] rd_word;
    logic [RD_W-1:0]   unused_rd_bus;
    logic [RD_EFF-1:0] unused_rd_word;

    assign wclk_i = WR_POL ? wr_clk : ~wr_clk;
    assign rclk_i = RD_POL ? rd_clk : ~rd_clk;

    aspect_ram_pack #(.BUS_W(WR_W), .EFF_W(WR_EFF), .ABITS(WR_AB)) u_wr_pack (
        .addr     (wr_addr),
        .bus_data (wr_data),
        .base     (wr_base),
        .word     (wr_word)
    );

    // the read side only needs the base; the data input is tied off
    assign unused_rd_bus = '0;
    aspect_ram_pack #(.BUS_W(RD_W), .EFF_W(RD_EFF), .ABITS(RD_AB)) u_rd_pack (
        .addr     (rd_addr),
        .bus_data (unused_rd_bus),
        .base     (rd_base),
        .word     (unused_rd_word)
    );

    aspect_ram_store #(
        .WW         (WR_EFF),
        .RW         (RD_EFF),
        .WIDE_LANES (WIDE_LANES),
        .COLLIDE    (COLLIDE),
        .INIT       (INIT)
    ) u_store (
        .wclk    (wclk_i),
        .wr_en   (wr_en),
        .wr_base (wr_base),
        .wr_word (wr_word),
        .rclk    (rclk_i),
        .rd_en   (rd_en),
        .rd_base (rd_base),
        .rd_word (rd_word)
    );

    aspect_ram_unpack #(.BUS_W(RD_W), .EFF_W(RD_EFF)) u_rd_unpack (
        .word     (rd_word),
        .bus_data (rd_data)
    );

endmodule

// File: rtl/aspect_ram_chk.sv
module aspect_ram_chk
    import aspect_ram_pkg::*;
#(
    parameter int WW = 20,
    parameter int RW = 20
) (
    input logic                  wclk,
    input logic                  rclk,
    input logic                  wr_en,
    input logic                  rd_en,
    input logic [FAW-1:0]        wr_base,
    input logic [WW-1:0]         wr_word,
    input logic [ARRAY_BITS-1:0] mem_q,
    input logic [RW-1:0]         rd_q
);
    logic w_live = 1'b0;
    logic r_live = 1'b0;

    always_ff @(posedge wclk) w_live <= 1'b1;
    always_ff @(posedge rclk) r_live <= 1'b1;

    function automatic logic [WW-1:0] word_at(input logic [ARRAY_BITS-1:0] m,
                                              input logic [FAW-1:0] b);
        return WW'(m >> b);
    endfunction

    function automatic logic [ARRAY_BITS-1:0] window(input logic [FAW-1:0] b);
        return ARRAY_BITS'({WW{1'b1}}) << b;
    endfunction

    // R4
    rd_hold_chk: assert property (@(posedge rclk) disable iff (!r_live)
        !rd_en |=> $stable(rd_q));

    // R5
    wr_idle_chk: assert property (@(posedge wclk) disable iff (!w_live)
        !wr_en |=> $stable(mem_q));

    // R6
    wr_lands_chk: assert property (@(posedge wclk) disable iff (!w_live)
        wr_en |=> (word_at(mem_q, $past(wr_base)) == $past(wr_word)));

    // R6
    wr_local_chk: assert property (@(posedge wclk) disable iff (!w_live)
        wr_en |=> (((mem_q ^ $past(mem_q)) & ~window($past(wr_base))) == '0));

endmodule

bind aspect_ram_store aspect_ram_chk #(.WW(WW), .RW(RW)) u_chk (
    .wclk    (wclk),
    .rclk    (rclk),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .wr_base (wr_base),
    .wr_word (wr_word),
    .mem_q   (mem_q),
    .rd_q    (rd_q)
);

// File: tb/aspect_ram_harness.sv
`timescale 1ns/1ps
module aspect_ram_harness
    import aspect_ram_pkg::*;
#(
    parameter int          CFG  = 0,
    parameter int          WW   = 20,
    parameter int          RW   = 20,
    parameter bit          POL  = 1'b1,
    parameter bit          NEWF = 1'b0,
    parameter int unsigned SEED = 1
) (
    input  logic clk,
    output logic done,
    output int   n_chk,
    output int   n_bad
);
    function automatic bit tb_wide(input int w);
        return w == 5 || w == 10 || w == 20;
    endfunction
    function automatic int tb_eff(input int w, input bit l5);
        if (l5) return w;
        if (w == 5) return 4;
        if (w == 10) return 8;
        if (w == 20) return 16;
        return w;
    endfunction
    function automatic int tb_ab(input int e);
        case (e)
            1: return 12;
            2: return 11;
            4, 5: return 10;
            8, 10: return 9;
            default: return 8;
        endcase
    endfunction
    function automatic logic [5119:0] make_init();
        logic [5119:0] r;
        for (int p = 0; p < 5120; p++) r[p] = ((p * 13 + p / 7) % 5) < 2;
        return r;
    endfunction

    localparam bit            L5   = tb_wide(WW) && tb_wide(RW);
    localparam int            WE   = tb_eff(WW, L5);
    localparam int            RE   = tb_eff(RW, L5);
    localparam int            WAB  = tb_ab(WE);
    localparam int            RAB  = tb_ab(RE);
    localparam logic [5119:0] IMG  = make_init();

    logic          wen, ren;
    logic [11:0]   waddr, raddr;
    logic [WW-1:0] wdata;
    logic [RW-1:0] rdata;
    logic [5119:0] ref_m;
    logic [RW-1:0] exp_q;

    aspect_ram #(
        .WR_W(WW), .RD_W(RW), .WR_POL(POL), .RD_POL(POL),
        .COLLIDE(collide_e'(NEWF)), .INIT(IMG)
    ) u_dut (
        .wr_clk(clk), .wr_en(wen), .wr_addr(waddr), .wr_data(wdata),
        .rd_clk(clk), .rd_en(ren), .rd_addr(raddr), .rd_data(rdata)
    );

    task automatic idle_edge();
        if (POL) @(negedge clk); else @(posedge clk);
    endtask

    function automatic logic [WE-1:0] pack_w(input logic [WW-1:0] d);
        logic [WE-1:0] r;
        if (WE == WW) return WE'(d);
        for (int g = 0; g < WE / 4; g++) r[g*4 +: 4] = d[g*5 +: 4];
        return r;
    endfunction

    function automatic logic [RW-1:0] unpack_r(input logic [RE-1:0] w);
        logic [RW-1:0] r;
        if (RE == RW) return RW'(w);
        r = '0;
        for (int g = 0; g < RE / 4; g++) r[g*5 +: 4] = w[g*4 +: 4];
        return r;
    endfunction

    function automatic logic [11:0] w_addr(input int field, input int low);
        return 12'((field << (12 - WAB)) | (low & ((1 << (12 - WAB)) - 1)));
    endfunction
    function automatic logic [11:0] r_addr(input int field, input int low);
        return 12'((field << (12 - RAB)) | (low & ((1 << (12 - RAB)) - 1)));
    endfunction

    task automatic check(input string tag);
        n_chk++;
        if (rdata !== exp_q) begin
            n_bad++;
            $display("FAIL cfg%0d %s: rd_data=%h expected %h", CFG, tag, rdata, exp_q);
        end
    endtask

    task automatic cycle(input bit we, input logic [11:0] wa, input logic [WW-1:0] wd,
                         input bit re, input logic [11:0] ra, input string tag);
        int            wbase, rbase;
        logic [WE-1:0] pw;
        logic [RE-1:0] rw;
        wen = we; waddr = wa; wdata = wd; ren = re; raddr = ra;
        wbase = int'(wa >> (12 - WAB)) * WE;
        rbase = int'(ra >> (12 - RAB)) * RE;
        pw = pack_w(wd);
        if (re) begin
            for (int i = 0; i < RE; i++) begin
                int f = rbase + i;
                rw[i] = ref_m[f];
                if (NEWF && we && f >= wbase && f < wbase + WE) rw[i] = pw[f - wbase];
            end
            exp_q = unpack_r(rw);
        end
        if (we) for (int j = 0; j < WE; j++) ref_m[wbase + j] = pw[j];
        idle_edge();
        check(tag);
    endtask

    function automatic logic [WW-1:0] rnd_w();
        logic [WW-1:0] r;
        for (int b = 0; b < WW; b++) r[b] = 1'($urandom());
        return r;
    endfunction

    initial begin
        done = 1'b0; n_chk = 0; n_bad = 0;
        wen = 1'b0; ren = 1'b0; waddr = '0; raddr = '0; wdata = '0;
        exp_q = '0;
        void'($urandom(SEED));
        for (int k = 0; k < 5120; k++) begin
            if (L5) ref_m[k] = IMG[k];
            else if (k < 4096) ref_m[k] = IMG[(k / 4) * 5 + k % 4];
            else ref_m[k] = 1'b0;
        end
        idle_edge();
        check("R11 power-up read data zero");

        for (int a = 0; a < 6; a++) cycle(0, 0, '0, 1, r_addr(a, 0), "R9 initial contents");
        cycle(0, 0, '0, 1, 12'hFFF, "R9 initial contents top word");

        for (int n = 0; n < 6; n++) begin
            int wf = int'($urandom_range(0, (1 << WAB) - 1));
            int rf = (wf * WE) / RE;
            cycle(1, w_addr(wf, -1), rnd_w(), 0, 0, "R4 hold during write");
            cycle(0, 0, '0, 1, r_addr(rf, int'($urandom())), "R1 low address bits ignored");
        end

        for (int n = 0; n < 4; n++) begin
            int wf = int'($urandom_range(0, (1 << WAB) - 1));
            cycle(0, w_addr(wf, 0), rnd_w(), 0, 0, "R5 disabled write");
            cycle(0, 0, '0, 1, r_addr((wf * WE) / RE, 0), "R5 word untouched");
        end

        for (int n = 0; n < 4; n++) begin
            int wf = int'($urandom_range(0, (1 << WAB) - 1));
            int rf = (wf * WE) / RE;
            cycle(0, 0, '0, 1, r_addr(rf, 0), "R4 enabled read");
            cycle(1, w_addr(wf, 0), ~exp_q[0] ? '1 : '0, 0, 0, "R4 rd_data held");
            cycle(0, 0, '0, 1, r_addr(rf, 0), "R2 lane payload and padding");
        end

        for (int n = 0; n < 12; n++) begin
            int wf = int'($urandom_range(0, (1 << WAB) - 1));
            int rf = (wf * WE) / RE;
            cycle(1, w_addr(wf, 0), rnd_w(), 1, r_addr(rf, 0),
                  NEWF ? "R8 same-edge read sees new data" : "R7 same-edge read sees old data");
        end

        for (int n = 0; n < 4; n++) begin
            int wf = int'($urandom_range(1, (1 << WAB) - 2));
            int rf = (wf * WE) / RE;
            cycle(1, w_addr(wf, 0), rnd_w(), 0, 0, "R4 hold during write");
            cycle(0, 0, '0, 1, r_addr((rf + (1 << RAB) - 1) % (1 << RAB), 0), "R6 lower neighbour");
            cycle(0, 0, '0, 1, r_addr((rf + 1) % (1 << RAB), 0), "R6 upper neighbour");
            cycle(0, 0, '0, 1, r_addr(rf, 0), "R6 written word");
        end

        for (int n = 0; n < 300; n++) begin
            bit          we = 1'($urandom());
            bit          re = ($urandom_range(0, 3) != 0);
            int          wf = int'($urandom_range(0, 7));
            logic [11:0] wa = ($urandom_range(0, 1) == 0) ? w_addr(wf, int'($urandom()))
                                                           : 12'($urandom());
            logic [11:0] ra = ($urandom_range(0, 1) == 0)
                              ? r_addr((wf * WE) / RE, int'($urandom())) : 12'($urandom());
            cycle(we, wa, rnd_w(), re, ra,
                  POL ? "R3 random mixed-width traffic" : "R3/R10 random traffic on falling edge");
        end

        wen = 1'b0; ren = 1'b0;
        done = 1'b1;
    end

endmodule

// File: tb/aspect_ram_tb.sv
`timescale 1ns/1ps
module aspect_ram_tb;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic done [5];
    int   nc   [5];
    int   nb   [5];
    logic timed_out = 1'b0;

    aspect_ram_harness #(.CFG(0), .WW(20), .RW(20), .POL(1'b1), .NEWF(1'b0), .SEED(11))
        h0 (.clk(clk), .done(done[0]), .n_chk(nc[0]), .n_bad(nb[0]));
    aspect_ram_harness #(.CFG(1), .WW(16), .RW(1), .POL(1'b1), .NEWF(1'b1), .SEED(23))
        h1 (.clk(clk), .done(done[1]), .n_chk(nc[1]), .n_bad(nb[1]));
    aspect_ram_harness #(.CFG(2), .WW(5), .RW(10), .POL(1'b0), .NEWF(1'b1), .SEED(37))
        h2 (.clk(clk), .done(done[2]), .n_chk(nc[2]), .n_bad(nb[2]));
    aspect_ram_harness #(.CFG(3), .WW(10), .RW(2), .POL(1'b1), .NEWF(1'b0), .SEED(41))
        h3 (.clk(clk), .done(done[3]), .n_chk(nc[3]), .n_bad(nb[3]));
    aspect_ram_harness #(.CFG(4), .WW(4), .RW(20), .POL(1'b0), .NEWF(1'b0), .SEED(59))
        h4 (.clk(clk), .done(done[4]), .n_chk(nc[4]), .n_bad(nb[4]));

    initial begin
        repeat (50000) @(posedge clk);
        timed_out = 1'b1;
    end

    initial begin
        int total;
        int bad;
        wait ((done[0] && done[1] && done[2] && done[3] && done[4]) || timed_out);
        total = 0;
        bad = 0;
        for (int i = 0; i < 5; i++) begin
            total += nc[i];
            bad   += nb[i];
        end
        if (timed_out) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete, actual timeout, expected completion");
        end
        $display("[TB] %0d tests run, %0d failed", total, bad);
        $finish;
    end
endmodule